// File: doc/BRIEF.md
# Framed Serial Command Word Receiver

This block takes 12-bit command words from a slow external serial link made of a clock line, a data line and an enable line, and presents each completed word to logic running on a faster system clock. All three serial inputs are brought into the system clock domain through synchroniser chains. Falling edges of the serial clock are then found from the synchronised clock history, and the data bit is taken at each of those edges.

The line idles at zero. A word begins with a high start bit, and the receiver then collects exactly eleven more bits. On the twelfth falling edge, counting the start bit as the first, it raises a one-cycle valid pulse. The first bit after the start bit selects the target: a control-register write or a converter-code write. The remaining ten bits are decoded into either the control fields or a channel index and an 8-bit code. Holding enable low keeps the shift logic in reset. Because idle zeros are discarded, a run of twelve zeros brings the receiver back to idle from any partial word.

Top module: `serial_word_rx`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, `word_valid`, `ctrl_wr` and `dac_wr` are 0, `word_sel` is 0 and `word_payload` is 0.
- R2: A serial bit is taken only on a falling edge of `ser_clk`. A value on `ser_data` that is present only while `ser_clk` is high and is changed before the fall is never captured.
- R3: While idle, a 0 sampled on a falling edge is discarded. A word starts only when a 1 is sampled.
- R4: A word completes on the twelfth falling edge, with the start bit counted as edge 1. After eleven edges there is no valid pulse, and each completed word gives exactly one `word_valid` pulse that lasts one system clock cycle.
- R5: The bit after the start bit appears on `word_sel`. When it is 0, `ctrl_wr` pulses with `word_valid`; when it is 1, `dac_wr` pulses. The ten bits that follow go to `word_payload`, and the first of them received lands at bit 9.
- R6: For a converter write, `dac_chan` is payload bits 9:8, where 0 selects channel A and 3 selects channel D. `dac_code` is payload bits 7:0, received most significant bit first.
- R7: For a control write, the ten payload bits arrive in this order: mode, range A to D, shutdown-inhibit A to D, activate. They appear on `ctrl_mode`, `ctrl_range[0..3]`, `ctrl_inhibit[0..3]` and `ctrl_act`, where index 0 is channel A.
- R8: While `ser_en` is low, falling edges have no effect and any partial word is dropped, so no `word_valid` is produced.
- R9: Twelve consecutive zeros clocked in return the receiver to idle from any partial word, so the next framed word is received correctly.
- R10: `word_sel`, `word_payload` and the decoded fields hold their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous, at most a quarter of `clk` |
| ser_data | input | 1 | Serial data |
| ser_en | input | 1 | Serial enable; low holds the shift logic in reset |
| word_valid | output | 1 | One-cycle pulse when a word completes |
| word_sel | output | 1 | Target select bit of the last word |
| word_payload | output | 10 | Ten bits following the select bit |
| ctrl_wr | output | 1 | Valid pulse for a control write |
| dac_wr | output | 1 | Valid pulse for a converter-code write |
| dac_chan | output | 2 | Channel index of the last word |
| dac_code | output | 8 | Converter code of the last word |
| ctrl_mode | output | 1 | Mode field |
| ctrl_range | output | 4 | Range fields, index 0 is channel A |
| ctrl_inhibit | output | 4 | Shutdown-inhibit fields, index 0 is channel A |
| ctrl_act | output | 1 | Activate field |

## Verification
The bench builds the block with the default two-stage synchronisers. It runs the serial clock at eight system cycles per bit, and every bit holds a decoy value for the first half of its high phase. With that latency and clock ratio, the valid pulse falls well inside one serial bit time, so each word can be checked as soon as its last bit has been sent. The decoy also exposes any sampling on the wrong edge. Partial words cut short by enable or flushed with zeros reach the idle and resynchronisation paths.

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_data,
  input  logic       ser_en,
  output logic       word_valid,
  output logic       word_sel,
  output logic [9:0] word_payload,
  output logic       ctrl_wr,
  output logic       dac_wr,
  output logic [1:0] dac_chan,
  output logic [7:0] dac_code,
  output logic       ctrl_mode,
  output logic [3:0] ctrl_range,
  output logic [3:0] ctrl_inhibit,
  output logic       ctrl_act
);

  localparam int WORD_BITS = 12;
  localparam int BODY_BITS = WORD_BITS - 1;
  localparam int CNT_W     = $clog2(WORD_BITS);
  localparam int CHANS     = 4;

  logic [SYNC_STAGES-1:0] ck_sync, dt_sync, en_sync;
  logic                   ck_last;
  logic                   busy;
  logic [CNT_W-1:0]       bit_cnt;
  logic [BODY_BITS-2:0]   shreg;
  logic [BODY_BITS-1:0]   word_q;

  wire ck_s = ck_sync[SYNC_STAGES-1];
  wire dt_s = dt_sync[SYNC_STAGES-1];
  wire en_s = en_sync[SYNC_STAGES-1];
  wire fall = ck_last & ~ck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sync <= '0;
      dt_sync <= '0;
      en_sync <= '0;
      ck_last <= 1'b0;
    end else begin
      ck_sync <= {ck_sync[SYNC_STAGES-2:0], ser_clk};
      dt_sync <= {dt_sync[SYNC_STAGES-2:0], ser_data};
      en_sync <= {en_sync[SYNC_STAGES-2:0], ser_en};
      ck_last <= ck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      word_q     <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (!en_s) begin
        busy    <= 1'b0;
        bit_cnt <= '0;
      end else if (fall) begin
        if (!busy) begin
          if (dt_s) begin
            busy    <= 1'b1;
            bit_cnt <= CNT_W'(1);
            shreg   <= '0;
          end
        end else begin
          shreg <= {shreg[BODY_BITS-3:0], dt_s};
          if (bit_cnt == CNT_W'(WORD_BITS - 1)) begin
            busy       <= 1'b0;
            bit_cnt    <= '0;
            word_valid <= 1'b1;
            word_q     <= {shreg, dt_s};
          end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assign word_sel     = word_q[BODY_BITS-1];
  assign word_payload = word_q[BODY_BITS-2:0];
  assign ctrl_wr      = word_valid & ~word_sel;
  assign dac_wr       = word_valid & word_sel;
  assign dac_chan     = word_payload[9:8];
  assign dac_code     = word_payload[7:0];
  assign ctrl_mode    = word_payload[9];
  assign ctrl_act     = word_payload[0];

  for (genvar i = 0; i < CHANS; i++) begin : g_fields
    assign ctrl_range[i]   = word_payload[8-i];
    assign ctrl_inhibit[i] = word_payload[4-i];
  end

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_valid_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(fall));

  assert_start_needs_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(dt_s));

  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!busy && bit_cnt == '0 && !word_valid));

  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> ($stable(word_payload) && $stable(word_sel)));

  always_ff @(posedge clk) begin
    if (rst_n) begin
      assert_count_bound_R9: assert (bit_cnt <= CNT_W'(WORD_BITS - 1));
    end
  end

endmodule

// File: tb/serial_word_rx_tb.sv
module serial_word_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b1, ser_data = 1'b0, ser_en = 1'b0;
  logic word_valid, word_sel, ctrl_wr, dac_wr, ctrl_mode, ctrl_act;
  logic [9:0] word_payload;
  logic [1:0] dac_chan;
  logic [7:0] dac_code;
  logic [3:0] ctrl_range, ctrl_inhibit;

  int vectors = 0, errors = 0, vcount = 0;
  logic cap_ctrl, cap_dac;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_word_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .word_valid(word_valid), .word_sel(word_sel), .word_payload(word_payload),
    .ctrl_wr(ctrl_wr), .dac_wr(dac_wr), .dac_chan(dac_chan), .dac_code(dac_code),
    .ctrl_mode(ctrl_mode), .ctrl_range(ctrl_range), .ctrl_inhibit(ctrl_inhibit),
    .ctrl_act(ctrl_act)
  );

  always @(negedge clk) begin
    if (word_valid) begin
      vcount   <= vcount + 1;
      cap_ctrl <= ctrl_wr;
      cap_dac  <= dac_wr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_data = ~b;
    ser_clk  = 1'b1;
    repeat (HALF_BIT/2) @(negedge clk);
    ser_data = b;
    repeat (HALF_BIT/2) @(negedge clk);
    ser_clk = 1'b0;
    repeat (HALF_BIT) @(negedge clk);
    ser_clk = 1'b1;
  endtask

  task automatic send_body(input logic [10:0] body, input int nbits);
    for (int i = 10; i > 10 - nbits; i--) send_bit(body[i]);
  endtask

  task automatic send_word(input logic [10:0] body);
    send_bit(1'b1);
    send_body(body, 11);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check(word_valid == 0 && ctrl_wr == 0 && dac_wr == 0, "R1 strobes", word_valid, 0);
    check(word_sel == 0 && word_payload == 0, "R1 fields", word_payload, 0);
  endtask

  task automatic t_dac;
    int c0 = vcount;
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    check(vcount == c0, "R3 idle zeros", vcount - c0, 0);
    send_word({1'b1, 2'b10, 8'hA5});
    check(vcount == c0 + 1, "R4 one pulse", vcount - c0, 1);
    check(cap_dac == 1 && cap_ctrl == 0, "R5 dac select", {cap_dac, cap_ctrl}, 2);
    check(word_payload == 10'h2A5, "R5 payload", word_payload, 10'h2A5);
    check(dac_chan == 2'd2, "R6 chan", dac_chan, 2);
    check(dac_code == 8'hA5, "R6 code", dac_code, 8'hA5);
    check(word_sel == 1'b1, "R2 decoy ignored sel", word_sel, 1);
  endtask

  task automatic t_boundary;
    int c0 = vcount;
    logic [10:0] body = {1'b1, 2'b01, 8'h3C};
    send_bit(1'b1);
    send_body(body, 10);
    repeat (8) @(negedge clk);
    check(vcount == c0, "R4 eleven edges", vcount - c0, 0);
    send_bit(body[0]);
    repeat (4) @(negedge clk);
    check(vcount == c0 + 1, "R4 twelfth edge", vcount - c0, 1);
    check(dac_chan == 2'd1 && dac_code == 8'h3C, "R6 chan B code", {dac_chan, dac_code}, 10'h13C);
  endtask

  task automatic t_ctrl;
    int c0 = vcount;
    send_word({1'b0, 1'b1, 4'b1000, 4'b0011, 1'b1});
    check(vcount == c0 + 1 && cap_ctrl == 1 && cap_dac == 0, "R5 ctrl select", {cap_ctrl, cap_dac}, 2);
    check(ctrl_mode == 1'b1, "R7 mode", ctrl_mode, 1);
    check(ctrl_range == 4'b0001, "R7 range", ctrl_range, 4'b0001);
    check(ctrl_inhibit == 4'b1100, "R7 inhibit", ctrl_inhibit, 4'b1100);
    check(ctrl_act == 1'b1, "R7 act", ctrl_act, 1);
    send_word({1'b0, 1'b0, 4'b0110, 4'b1000, 1'b0});
    check(ctrl_range == 4'b0110 && ctrl_inhibit == 4'b0001 && ctrl_act == 0 && ctrl_mode == 0,
          "R7 second pattern", {ctrl_range, ctrl_inhibit}, 8'h61);
  endtask

  task automatic t_enable;
    int c0 = vcount;
    @(negedge clk) ser_en = 1'b0;
    repeat (4) @(negedge clk);
    send_word({1'b1, 2'b11, 8'hFF});
    check(vcount == c0, "R8 disabled word", vcount - c0, 0);
    @(negedge clk) ser_en = 1'b1;
    repeat (4) @(negedge clk);
    send_bit(1'b1);
    send_body({1'b1, 2'b11, 8'hFF}, 6);
    @(negedge clk) ser_en = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge clk) ser_en = 1'b1;
    repeat (4) @(negedge clk);
    send_word({1'b1, 2'b00, 8'h5A});
    check(vcount == c0 + 1, "R8 partial dropped", vcount - c0, 1);
    check(dac_chan == 2'd0 && dac_code == 8'h5A, "R8 word after enable", dac_code, 8'h5A);
  endtask

  task automatic t_resync;
    int c0;
    send_bit(1'b1);
    send_body(11'h7FF, 4);
    for (int i = 0; i < 12; i++) send_bit(1'b0);
    repeat (4) @(negedge clk);
    c0 = vcount;
    send_word({1'b1, 2'b11, 8'h81});
    check(vcount == c0 + 1, "R9 single word after flush", vcount - c0, 1);
    check(dac_chan == 2'd3 && dac_code == 8'h81, "R9 resync value", {dac_chan, dac_code}, 10'h381);
  endtask

  task automatic t_hold;
    int c0 = vcount;
    logic [9:0] p0 = word_payload;
    for (int i = 0; i < 14; i++) send_bit(1'b0);
    check(vcount == c0, "R10 no pulse on zeros", vcount - c0, 0);
    check(word_payload == p0 && word_sel == 1'b1, "R10 fields held", word_payload, p0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    ser_en = 1'b1;
    repeat (4) @(negedge clk);
    t_dac();
    t_boundary();
    t_ctrl();
    t_enable();
    t_resync();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule